// File: doc/BRIEF.md
# Four-Core TDM Frame Summer with DAC Output Register

This block sits at the end of a time-multiplexed modulator built from four parallel arithmetic cores. Each core serves ten channels, one per slot of a ten-slot frame. In every cycle each core presents one signed 16-bit RF sample. The block adds the four samples in one cycle. It then accumulates these per-cycle sums over the whole frame in a register wide enough for all forty channels. In the last slot of the frame it produces one output sample for the digital-to-analog converter.

The output word keeps the most significant bits of the frame total. Its sign bit is inverted, so the converter receives offset binary. The word is registered and holds its value between frames. A single-cycle strobe marks each new sample. Samples are taken only while the frame-aligned valid input is high. When valid is low, both the samples and the slot index are disregarded.

Top module: `tdm_sum_dac`

## Requirements
- R1: Reset is asynchronous and active low. It clears the accumulator and discards any partial frame. It sets the output word to mid-scale (only the top bit set, 2048 for a 12-bit width) and sets the strobe low.
- R2: In every valid cycle the signed sum of all four core samples is added to the accumulator. Core k's sample occupies bits [16k+15:16k] of the packed sample input.
- R3: The accumulator is 22 bits wide by default. It holds the total of forty full-scale samples of the same sign (+1310680 or -1310720) without wrapping.
- R4: The output word changes only on a valid cycle whose slot index equals 9. In every other cycle it keeps its value.
- R5: The total written at slot 9 includes that cycle's four samples. The following frame then starts from an accumulator of zero.
- R6: The output word is the frame total arithmetically shifted right by (22 − DAC width). Its top DAC-width bits are kept, so negative totals round toward minus infinity.
- R7: The sign bit of the kept bits is inverted, so a total of zero drives mid-scale and the most negative value drives code 0.
- R8: The strobe is high for exactly the one cycle after each output update, and low in all other cycles.
- R9: A cycle with valid low changes neither the accumulator nor the output. This holds even when its slot index is 9 and its samples are non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the cores |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_in | input | 64 | Four signed 16-bit core samples, core 0 in the low bits |
| slot | input | 4 | Current slot index, 0 to 9 |
| slot_valid | input | 1 | Samples and slot index are valid this cycle |
| dac_q | output | 12 | Registered offset-binary output word |
| dac_stb | output | 1 | One-cycle marker of a new output word |

## Verification
The bench targets three frame types.
- Frames where only the last slot carries signal. A design that closed the frame before adding the slot-9 sum would output mid-scale for these.
- Small negative totals. A design that truncated toward zero, or left the sign bit as it was, would be off by one code or by half the scale.
- Frames at full positive and full negative scale. A narrow or unsigned accumulator would wrap these to the wrong side.

Invalid cycles carrying slot 9 and junk samples are placed both inside frames and after them. This exposes an update or strobe that ignores the valid input. A reset in mid-frame exposes partial sums that leak into the next frame. Single-core frames expose a lane that is dropped or sign-extended incorrectly.

// File: rtl/tdm_sum_pkg.sv
package tdm_sum_pkg;

    localparam int unsigned DEF_CORES    = 4;
    localparam int unsigned DEF_SLOTS    = 10;
    localparam int unsigned DEF_SAMPLE_W = 16;
    localparam int unsigned DEF_DAC_W    = 12;
    localparam int unsigned DEF_SLOT_W   = 4;

    // Smallest signed width holding cores*slots samples of sample_w bits.
    function automatic int unsigned acc_width_for(input int unsigned cores,
                                                  input int unsigned slots,
                                                  input int unsigned sample_w);
        return sample_w + $clog2(cores * slots);
    endfunction

endpackage

// File: rtl/tdm_sum_tree.sv
// Combinational pairwise adder tree over the packed core samples.
module tdm_sum_tree #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned ACC_W    = 22
) (
    input  logic [N_CORES*SAMPLE_W-1:0] rf_in,
    output logic signed [ACC_W-1:0]     sum_o
);
    localparam int unsigned LEVELS = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int unsigned PAD    = 1 << LEVELS;
    localparam int unsigned EXT_W  = ACC_W - SAMPLE_W;

    // Heap layout: leaves at PAD..2*PAD-1, root at 1.
    logic signed [ACC_W-1:0] node [1:2*PAD-1];

    for (genvar k = 0; k < PAD; k++) begin : g_leaf
        if (k < N_CORES) begin : g_used
            assign node[PAD+k] = {{EXT_W{rf_in[k*SAMPLE_W+SAMPLE_W-1]}},
                                  rf_in[k*SAMPLE_W +: SAMPLE_W]};
        end else begin : g_pad
            assign node[PAD+k] = '0;
        end
    end

    for (genvar i = 1; i < PAD; i++) begin : g_add
        assign node[i] = node[2*i] + node[2*i+1];
    end

    assign sum_o = node[1];
endmodule

// File: rtl/tdm_sum_acc.sv
// Frame accumulator: adds one tree sum per valid cycle and closes at the last slot.
module tdm_sum_acc #(
    parameter int unsigned N_SLOTS = 10,
    parameter int unsigned SLOT_W  = 4,
    parameter int unsigned ACC_W   = 22,
    parameter int unsigned DAC_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_valid,
    input  logic [SLOT_W-1:0]        slot,
    input  logic signed [ACC_W-1:0]  tree_sum,
    output logic                     close_evt,
    output logic [DAC_W-1:0]         close_top,
    output logic signed [ACC_W-1:0]  acc_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic signed [ACC_W-1:0] frame_total;

    always_comb begin
        st_d        = st_q;
        frame_total = st_q.acc + tree_sum;
        close_evt   = slot_valid && (slot == LAST_SLOT);
        close_top   = frame_total[ACC_W-1 -: DAC_W];
        if (slot_valid) begin
            st_d.acc = close_evt ? '0 : frame_total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
endmodule

// File: rtl/tdm_sum_out.sv
// Output register: offset-binary conversion, hold between frames, one-cycle strobe.
module tdm_sum_out #(
    parameter int unsigned DAC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_evt,
    input  logic [DAC_W-1:0] close_top,
    output logic [DAC_W-1:0] dac_q,
    output logic             dac_stb
);
    localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};

    typedef struct packed {
        logic [DAC_W-1:0] word;
        logic             stb;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (close_evt) begin
            st_d.word = {~close_top[DAC_W-1], close_top[DAC_W-2:0]};
            st_d.stb  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= MID_CODE;
            st_q.stb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_q   = st_q.word;
    assign dac_stb = st_q.stb;
endmodule

// File: rtl/tdm_sum_dac.sv
module tdm_sum_dac #(
    parameter int unsigned N_CORES  = tdm_sum_pkg::DEF_CORES,
    parameter int unsigned N_SLOTS  = tdm_sum_pkg::DEF_SLOTS,
    parameter int unsigned SAMPLE_W = tdm_sum_pkg::DEF_SAMPLE_W,
    parameter int unsigned SLOT_W   = tdm_sum_pkg::DEF_SLOT_W,
    parameter int unsigned DAC_W    = tdm_sum_pkg::DEF_DAC_W,
    parameter int unsigned ACC_W    = tdm_sum_pkg::acc_width_for(N_CORES, N_SLOTS, SAMPLE_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES*SAMPLE_W-1:0] rf_in,
    input  logic [SLOT_W-1:0]           slot,
    input  logic                        slot_valid,
    output logic [DAC_W-1:0]            dac_q,
    output logic                        dac_stb
);
    logic signed [ACC_W-1:0] tree_sum;
    logic signed [ACC_W-1:0] acc_now;
    logic                    close_evt;
    logic [DAC_W-1:0]        close_top;

    tdm_sum_tree #(
        .N_CORES (N_CORES),
        .SAMPLE_W(SAMPLE_W),
        .ACC_W   (ACC_W)
    ) u_tree (
        .rf_in(rf_in),
        .sum_o(tree_sum)
    );

    tdm_sum_acc #(
        .N_SLOTS(N_SLOTS),
        .SLOT_W (SLOT_W),
        .ACC_W  (ACC_W),
        .DAC_W  (DAC_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_valid(slot_valid),
        .slot      (slot),
        .tree_sum  (tree_sum),
        .close_evt (close_evt),
        .close_top (close_top),
        .acc_o     (acc_now)
    );

    tdm_sum_out #(
        .DAC_W(DAC_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .close_evt(close_evt),
        .close_top(close_top),
        .dac_q    (dac_q),
        .dac_stb  (dac_stb)
    );
endmodule

// File: rtl/tdm_sum_dac_chk.sv
module tdm_sum_dac_chk #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned N_SLOTS  = 10,
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned SLOT_W   = 4,
    parameter int unsigned DAC_W    = 12,
    parameter int unsigned ACC_W    = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SLOT_W-1:0]       slot,
    input logic                    slot_valid,
    input logic [DAC_W-1:0]        dac_q,
    input logic                    dac_stb,
    input logic signed [ACC_W-1:0] acc
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
    localparam logic [DAC_W-1:0]  MID_CODE  = {1'b1, {(DAC_W-1){1'b0}}};
    localparam longint            ACC_LIM   = longint'(N_CORES) * longint'(N_SLOTS)
                                              * (longint'(1) << (SAMPLE_W - 1));

    AST_RESET_MID: assert property (@(posedge clk)
        !rst_n |=> (dac_q == MID_CODE) && !dac_stb); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(acc) <= ACC_LIM) && (longint'(acc) >= -ACC_LIM)); // R3

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_stb |-> $stable(dac_q)); // R4

    AST_STB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_stb |-> $past(slot_valid && (slot == LAST_SLOT))); // R4

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        dac_stb |-> (acc == '0)); // R5

    AST_STB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && (slot == LAST_SLOT)) |=> dac_stb); // R8

    AST_STB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_valid && (slot == LAST_SLOT)) |=> !dac_stb); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slot_valid) |-> $stable(acc)); // R9
endmodule

bind tdm_sum_dac tdm_sum_dac_chk #(
    .N_CORES (N_CORES),
    .N_SLOTS (N_SLOTS),
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W),
    .DAC_W   (DAC_W),
    .ACC_W   (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .slot_valid(slot_valid),
    .dac_q     (dac_q),
    .dac_stb   (dac_stb),
    .acc       (acc_now)
);

// File: tb/tdm_sum_dac_bench.sv
module tdm_sum_dac_bench;
    localparam int CORES  = 4;
    localparam int SLOTS  = 10;
    localparam int SW     = 16;
    localparam int SLW    = 4;
    localparam int DW     = 12;
    localparam int AW     = 22;
    localparam int SHIFT  = AW - DW;
    localparam longint MID = longint'(1) << (DW - 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [CORES*SW-1:0]   rf_in = '0;
    logic [SLW-1:0]        slot = '0;
    logic                  slot_valid = 1'b0;
    logic [DW-1:0]         dac_q;
    logic                  dac_stb;

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint run_sum = 0;
    longint last_code = MID;
    int     lcg = 32'h1357_9bdf;

    always #5 clk = ~clk;

    tdm_sum_dac u_tdm_sum_dac (
        .clk       (clk),
        .rst_n     (rst_n),
        .rf_in     (rf_in),
        .slot      (slot),
        .slot_valid(slot_valid),
        .dac_q     (dac_q),
        .dac_stb   (dac_stb)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint code_of(input longint total);
        longint sh;
        sh = total >>> SHIFT;
        return (sh & ((longint'(1) << DW) - 1)) ^ MID;
    endfunction

    function int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return lcg;
    endfunction

    function int sample_for(input int kind, input int p, input int s, input int k);
        case (kind)
            0: return 32767;
            1: return -32768;
            2: return (k == p) ? (s * 6007 - 30000) : 0;
            3: return (next_rand() >>> 8) % 32768;
            4: return p;
            5: return (s == SLOTS - 1) ? p : 0;
            default: return 0;
        endcase
    endfunction

    task automatic drive(input bit v, input int s, input int smp[CORES]);
        slot_valid = v;
        slot       = SLW'(s);
        for (int k = 0; k < CORES; k++) begin
            rf_in[k*SW +: SW] = SW'(smp[k]);
            if (v) run_sum += smp[k];
        end
    endtask

    task automatic junk_cycle();
        int j[CORES];
        for (int k = 0; k < CORES; k++) j[k] = (next_rand() >>> 4) % 32768;
        drive(1'b0, SLOTS - 1, j);
    endtask

    // One frame; optional invalid gap carrying slot 9 and junk in mid-frame.
    task automatic play_frame(input int kind, input int p, input bit gap);
        int     smp[CORES];
        longint exp;
        run_sum = 0;
        for (int s = 0; s < SLOTS; s++) begin
            @(negedge clk);
            if (gap && s == 5) begin
                junk_cycle();
                @(negedge clk);
                check("R9 strobe on invalid cycle", longint'(dac_stb), 0);
                check("R9 output on invalid cycle", longint'(dac_q), last_code);
            end
            for (int k = 0; k < CORES; k++) smp[k] = sample_for(kind, p, s, k);
            drive(1'b1, s, smp);
        end
        exp = code_of(run_sum);
        @(negedge clk);
        check("R5 R6 R7 frame code", longint'(dac_q), exp);
        check("R8 strobe after last slot", longint'(dac_stb), 1);
        junk_cycle();
        @(negedge clk);
        check("R8 strobe single cycle", longint'(dac_stb), 0);
        check("R4 output held", longint'(dac_q), exp);
        last_code = exp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(10 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int z[CORES];
        for (int k = 0; k < CORES; k++) z[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset output mid-scale", longint'(dac_q), MID);
        check("R1 reset strobe low", longint'(dac_stb), 0);
        rst_n = 1'b1;

        // R3: full-scale frames of both signs
        play_frame(0, 0, 1'b0);
        check("R3 full positive", last_code, code_of(40 * 32767));
        play_frame(1, 0, 1'b0);
        check("R3 full negative", last_code, 768);
        play_frame(6, 0, 1'b0);
        check("R7 zero total mid-scale", last_code, MID);

        // R2: each core lane alone
        for (int k = 0; k < CORES; k++) play_frame(2, k, 1'b1);

        // R5: only the last slot carries signal
        for (int p = -32768; p <= 32767; p += 997) play_frame(5, p, 1'b0);

        // R6: constant sweeps across truncation boundaries, incl. small negatives
        for (int p = -80; p <= 80; p++) play_frame(4, p, (p % 7) == 0);
        play_frame(4, -1, 1'b0);
        check("R6 floor of minus forty", last_code, 2047);

        // R2 R9: pseudo-random frames with gaps
        for (int i = 0; i < 60; i++) play_frame(3, 0, i[0]);

        // R1: reset in mid-frame discards the partial sum
        run_sum = 0;
        for (int s = 0; s < 5; s++) begin
            int m[CORES];
            @(negedge clk);
            for (int k = 0; k < CORES; k++) m[k] = 32767;
            drive(1'b1, s, m);
        end
        @(negedge clk);
        drive(1'b0, 0, z);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-frame reset output", longint'(dac_q), MID);
        check("R1 mid-frame reset strobe", longint'(dac_stb), 0);
        rst_n = 1'b1;
        last_code = MID;
        play_frame(2, 1, 1'b0);

        @(negedge clk);
        finish_run();
    end
endmodule